// File: doc/BRIEF.md
# Nibble-Serial Converter Front-End Link

This block sits between a modem core and an external analog converter. The converter exchanges 16-bit samples over narrow 4-bit buses, so each sample word crosses the pins as four nibbles on four consecutive clock cycles. On the receive side, the block rebuilds parallel words from the incoming nibble stream. An external word-start strobe marks the cycle that carries the first nibble of each word.

On the transmit side, the block takes two parallel words from the core on every word boundary. One is the transmit sample and the other is the echo-path sample. It sends them out as nibbles on two independent 4-bit buses. A single frame counter sets the nibble phase for both directions. The first word-start strobe after reset aligns it, later strobes realign it, and between strobes it free-runs.

A loopback selector can replace the external receive nibble bus with the block's own transmit-data nibble bus. This lets the receive path be tested without the converter.

Top module: `nafe_link`

## Requirements
- R1: After reset, and until the first cycle with `rx_sow` high, `rx_word` is 0, `rx_word_vld` is 0, `tx_take` is 0, and both transmit nibble buses drive 0, whatever arrives on `rx_nib`.
- R2: The cycle with `rx_sow` high is nibble phase 0, and the next three cycles are phases 1, 2 and 3. The receive word is assembled most significant nibble first: the phase 0 nibble lands in bits 15:12 and the phase 3 nibble in bits 3:0.
- R3: `rx_word_vld` is high for exactly one cycle, the cycle after the phase 3 nibble. `rx_word` changes only in that cycle and holds its value otherwise.
- R4: If `rx_sow` arrives before a started word has reached phase 3, the partial word is dropped and produces no valid pulse. The strobe cycle becomes phase 0 of a new word.
- R5: Once aligned, the phase counter keeps cycling 0 to 3 without further strobes, and a receive word completes every four cycles.
- R6: `tx_take` is high exactly in phase 3 cycles. At the end of such a cycle the block samples `tx_data_word` and `tx_echo_word`.
- R7: The data word sampled at a phase 3 cycle appears on `tx_data_nib` during the following phases 0, 1, 2 and 3, most significant nibble first. Before the first sampling, the bus carries 0.
- R8: The echo word leaves on `tx_echo_nib` with the same timing and order as R7, independently of the data word's value.
- R9: While `lpbk_en` is 1, the receive path takes its nibbles from `tx_data_nib` instead of `rx_nib`. An aligned receive word then equals the data word being sent in that frame, and `rx_nib` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lpbk_en | input | 1 | 1 selects the transmit data nibble bus as the receive source |
| rx_nib | input | 4 | Receive nibble bus from the converter |
| rx_sow | input | 1 | Start-of-word strobe, high on the first nibble of a receive word |
| rx_word | output | 16 | Assembled receive sample |
| rx_word_vld | output | 1 | One-cycle pulse marking a new `rx_word` |
| tx_data_word | input | 16 | Transmit sample from the core |
| tx_echo_word | input | 16 | Echo-path sample from the core |
| tx_take | output | 1 | High in the cycle at whose end both transmit words are sampled |
| tx_data_nib | output | 4 | Transmit data nibble bus |
| tx_echo_nib | output | 4 | Transmit echo nibble bus |

## Verification
Almost every error in this block is an error in the shared phase counter or in a held word. A counter that is off by one, fails to reset on a strobe, or wraps wrongly shows up at the ports within one four-cycle frame. It appears as a receive word whose nibbles are rotated, a valid pulse in the wrong cycle, or `tx_take` outside phase 3. A transmit holding register that is loaded at the wrong time or with the wrong nibble order is visible in the next frame on the nibble buses. Loopback errors show up as a receive word that differs from the data word being sent.

// File: rtl/nafe_pkg.sv
package nafe_pkg;
  localparam int unsigned NAFE_WORD_W = 16;
  localparam int unsigned NAFE_NIB_W  = 4;
  localparam int unsigned NAFE_LANES  = 2;
  typedef enum logic {LANE_DATA = 1'b0, LANE_ECHO = 1'b1} nafe_lane_e;
endpackage

// File: rtl/nafe_frame.sv
module nafe_frame #(
  parameter int unsigned NIBS = 4,
  localparam int unsigned PH_W = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sow_i,
  output logic            lock_o,
  output logic [PH_W-1:0] cur_ph_o,
  output logic            wend_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NIBS - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            lock_q, lock_d;

  always_comb begin
    ph_d   = ph_q;
    lock_d = lock_q;
    if (sow_i) begin
      ph_d   = PH_W'(1);
      lock_d = 1'b1;
    end else if (lock_q) begin
      ph_d = (ph_q == LAST) ? '0 : ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o   = lock_q | sow_i;
  assign cur_ph_o = sow_i ? '0 : ph_q;
  assign wend_o   = lock_q & ~sow_i & (ph_q == LAST);

  // R4: a strobe always starts a fresh count at phase 1 next cycle
  a_r4_sow_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sow_i |=> (lock_q && ph_q == PH_W'(1)));
  // R5: after the last phase the counter comes back to zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wend_o |=> (ph_q == '0));
endmodule

// File: rtl/nafe_rx_asm.sv
module nafe_rx_asm #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned SH_W  = WORD_W - NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              wend_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;

  always_comb begin
    sh_d   = sh_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (lock_i) begin
      sh_d = SH_W'({sh_q, nib_i});
    end
    if (wend_i) begin
      word_d = {sh_q, nib_i};
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // R3: valid never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R3: the word only moves together with the valid pulse
  a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(word_q));
endmodule

// File: rtl/nafe_tx_lane.sv
module nafe_tx_lane #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned NIBS  = WORD_W / NIB_W,
  localparam int unsigned PH_W  = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              wend_i,
  input  logic [PH_W-1:0]   cur_ph_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NIB_W-1:0]  nib_o
);
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [NIB_W-1:0]  nib_q, nib_d;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = hold_q << (NIB_W * (32'(cur_ph_i) + 32'd1));
    hold_d  = hold_q;
    nib_d   = nib_q;
    if (wend_i) begin
      hold_d = word_i;
      nib_d  = word_i[WORD_W-1 -: NIB_W];
    end else if (lock_i) begin
      nib_d = shifted[WORD_W-1 -: NIB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      nib_q  <= '0;
    end else begin
      hold_q <= hold_d;
      nib_q  <= nib_d;
    end
  end

  assign nib_o = nib_q;

  // R1: the lane stays quiet until the frame is aligned
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |-> (nib_q == '0));
  // R7: the first nibble after a take is the top of the sampled word
  a_r7_first_nib: assert property (@(posedge clk) disable iff (!rst_n)
    wend_i |=> (nib_q == $past(word_i[WORD_W-1 -: NIB_W])));
endmodule

// File: rtl/nafe_link.sv
module nafe_link #(
  parameter int unsigned WORD_W = nafe_pkg::NAFE_WORD_W,
  parameter int unsigned NIB_W  = nafe_pkg::NAFE_NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpbk_en,
  input  logic [NIB_W-1:0]  rx_nib,
  input  logic              rx_sow,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_word_vld,
  input  logic [WORD_W-1:0] tx_data_word,
  input  logic [WORD_W-1:0] tx_echo_word,
  output logic              tx_take,
  output logic [NIB_W-1:0]  tx_data_nib,
  output logic [NIB_W-1:0]  tx_echo_nib
);
  import nafe_pkg::*;
  localparam int unsigned NIBS  = WORD_W / NIB_W;
  localparam int unsigned PH_W  = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam int unsigned LANES = NAFE_LANES;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic            lock;
  logic            wend;
  logic [PH_W-1:0] cur_ph;

  nafe_frame #(.NIBS(NIBS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sow_i    (rx_sow),
    .lock_o   (lock),
    .cur_ph_o (cur_ph),
    .wend_o   (wend)
  );

  logic [WORD_W-1:0] lane_word [LANES];
  logic [NIB_W-1:0]  lane_nib  [LANES];

  assign lane_word[LANE_DATA] = tx_data_word;
  assign lane_word[LANE_ECHO] = tx_echo_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    nafe_tx_lane #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .lock_i   (lock),
      .wend_i   (wend),
      .cur_ph_i (cur_ph),
      .word_i   (lane_word[g]),
      .nib_o    (lane_nib[g])
    );
  end

  logic [NIB_W-1:0] rx_src;
  assign rx_src = lpbk_en ? lane_nib[LANE_DATA] : rx_nib;

  nafe_rx_asm #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lock_i (lock),
    .wend_i (wend),
    .nib_i  (rx_src),
    .word_o (rx_word),
    .vld_o  (rx_word_vld)
  );

  assign tx_take     = wend;
  assign tx_data_nib = lane_nib[LANE_DATA];
  assign tx_echo_nib = lane_nib[LANE_ECHO];

  // R6: a take is always followed by the first cycle of a new frame
  a_r6_take_then_valid: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_take |=> rx_word_vld);
endmodule

// File: tb/sim_nafe_link.sv
module sim_nafe_link;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lpbk_en;
  logic [3:0]  rx_nib;
  logic        rx_sow;
  logic [15:0] rx_word;
  logic        rx_word_vld;
  logic [15:0] tx_data_word;
  logic [15:0] tx_echo_word;
  logic        tx_take;
  logic [3:0]  tx_data_nib;
  logic [3:0]  tx_echo_nib;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  nafe_link u0 (
    .clk(clk), .rst_n(rst_n), .lpbk_en(lpbk_en), .rx_nib(rx_nib), .rx_sow(rx_sow),
    .rx_word(rx_word), .rx_word_vld(rx_word_vld), .tx_data_word(tx_data_word),
    .tx_echo_word(tx_echo_word), .tx_take(tx_take), .tx_data_nib(tx_data_nib),
    .tx_echo_nib(tx_echo_nib)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R1: reset state and ignoring input before alignment
  task automatic t_reset_idle();
    rst_n = 1'b0; lpbk_en = 1'b0; rx_nib = 4'h0; rx_sow = 1'b0;
    tx_data_word = 16'h0; tx_echo_word = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(rx_word == 16'h0, "R1", "reset rx_word", rx_word, 16'h0);
    chk(rx_word_vld == 1'b0, "R1", "reset vld", 16'(rx_word_vld), 16'h0);
    chk(tx_take == 1'b0, "R1", "reset take", 16'(tx_take), 16'h0);
    chk(tx_data_nib == 4'h0 && tx_echo_nib == 4'h0, "R1", "reset tx nibs",
        {8'h0, tx_data_nib, tx_echo_nib}, 16'h0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_nib = 4'(i + 9); tx_data_word = 16'hDEAD; tx_echo_word = 16'hBEEF;
      #1;
      chk(tx_take == 1'b0, "R1", "take before align", 16'(tx_take), 16'h0);
      @(posedge clk); #1;
      chk(rx_word_vld == 1'b0 && rx_word == 16'h0, "R1", "rx before align",
          rx_word, 16'h0);
      chk(tx_data_nib == 4'h0 && tx_echo_nib == 4'h0, "R1", "tx before align",
          {8'h0, tx_data_nib, tx_echo_nib}, 16'h0);
    end
  endtask

  // one four-cycle frame; checks R2 R3 R5 R6 R7 R8 R9 as asked
  task automatic run_word(input logic [15:0] rxw, input bit sow0,
                          input logic [15:0] nd, input logic [15:0] ne,
                          input bit chk_tx, input logic [15:0] exd,
                          input logic [15:0] exe, input bit lb, input string req);
    logic [15:0] got_d = 16'h0;
    logic [15:0] got_e = 16'h0;
    logic [15:0] exp_rx;
    exp_rx = lb ? exd : rxw;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_nib = lb ? ~rxw[15 - 4*i -: 4] : rxw[15 - 4*i -: 4];
      rx_sow = sow0 && (i == 0);
      tx_data_word = nd; tx_echo_word = ne;
      #1;
      got_d = {got_d[11:0], tx_data_nib};
      got_e = {got_e[11:0], tx_echo_nib};
      chk(tx_take == (i == 3), "R6", $sformatf("%s take phase %0d", req, i),
          16'(tx_take), 16'(i == 3));
      if (i > 0)
        chk(rx_word_vld == 1'b0, "R3", $sformatf("%s vld phase %0d", req, i),
            16'(rx_word_vld), 16'h0);
    end
    @(posedge clk); #1;
    rx_sow = 1'b0;
    chk(rx_word_vld == 1'b1, "R3", {req, " vld after phase 3"}, 16'(rx_word_vld), 16'h1);
    chk(rx_word == exp_rx, lb ? "R9" : "R2", {req, " rx word"}, rx_word, exp_rx);
    if (chk_tx) begin
      chk(got_d == exd, "R7", {req, " data lane"}, got_d, exd);
      chk(got_e == exe, "R8", {req, " echo lane"}, got_e, exe);
    end
  endtask

  // R4: partial word cut short by a new strobe
  task automatic t_partial();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      rx_nib = 4'(4'h3 + i); rx_sow = (i == 0);
      @(posedge clk); #1;
      if (i > 0)
        chk(rx_word_vld == 1'b0, "R4", "vld inside partial", 16'(rx_word_vld), 16'h0);
    end
    rx_sow = 1'b0;
  endtask

  task automatic t_stream();
    run_word(16'hA5C3, 1'b1, 16'h1234, 16'hABCD, 1'b1, 16'h0000, 16'h0000, 1'b0, "R7 first");
    run_word(16'h0F1E, 1'b1, 16'h5678, 16'h9ABC, 1'b1, 16'h1234, 16'hABCD, 1'b0, "R8 second");
    run_word(16'h7E81, 1'b0, 16'h0000, 16'hFFFF, 1'b1, 16'h5678, 16'h9ABC, 1'b0, "R5 freerun");
    run_word(16'h3C96, 1'b0, 16'hC001, 16'h0FF0, 1'b1, 16'h0000, 16'hFFFF, 1'b0, "R5 freerun2");
  endtask

  task automatic t_restart();
    t_partial();
    run_word(16'h8421, 1'b1, 16'h2468, 16'h1357, 1'b0, 16'h0, 16'h0, 1'b0, "R4 restart");
    run_word(16'h6B2D, 1'b0, 16'hE1E1, 16'h5A5A, 1'b1, 16'h2468, 16'h1357, 1'b0, "R4 after");
  endtask

  // R9: loopback takes the transmit data lane, ignoring rx_nib
  task automatic t_loop();
    lpbk_en = 1'b1;
    run_word(16'h1111, 1'b1, 16'h4D2C, 16'h0001, 1'b1, 16'hE1E1, 16'h5A5A, 1'b1, "R9 loop a");
    run_word(16'h2222, 1'b0, 16'h9999, 16'h0002, 1'b1, 16'h4D2C, 16'h0001, 1'b1, "R9 loop b");
    lpbk_en = 1'b0;
    run_word(16'hBEAD, 1'b1, 16'h0000, 16'h0000, 1'b1, 16'h9999, 16'h0002, 1'b0, "R9 loop off");
  endtask

  initial begin
    t_reset_idle();
    t_stream();
    t_restart();
    t_loop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule